// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the host side of a two-wire management bus for Ethernet PHYs. It generates the management clock and drives a bidirectional data line through separate output, output-enable and input signals, so the pad ring builds the tristate buffer. The host loads a transaction with a single start pulse. The transaction carries a read/write select, a select between the short (Clause 22) and extended (Clause 45) frame styles, a 5-bit PHY address, a 21-bit register address and 16 bits of write data. The block raises `busy_o` and runs the whole exchange on the bus. At the end it pulses `done_o` for one cycle, with read results held on `rdata_o`.

A short-format access is one frame. An extended access is two frames to the same PHY and device. The first frame loads the low 16 address bits and is framed like a write. The second frame carries the read or write opcode. On reads, the turnaround bit returned by the PHY is checked. A PHY whose bit is set in `ta_mask_i` is trusted even when its turnaround is wrong. Any other PHY that answers with a high turnaround has 32 further bits clocked out and discarded, and the read returns all ones. The length of each clock phase is set in system-clock cycles by parameters. The high phase of a bit the master samples is stretched to give the PHY time to present data.

Top module: `mdio_master`

## Requirements
- R1: After reset `mdc_o` is 0, `mdio_oe_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: Every frame opens with 32 bits of value 1, each with `mdio_oe_o` high.
- R3: A short-format frame sends start bits 0,1, then a 2-bit opcode, then `phy_i` (5 bits) and `addr_i[4:0]` (5 bits). Every field is sent most significant bit first.
- R4: Write and address frames drive turnaround 1,0, then 16 data bits MSB first. They then release the line for one final clocked bit. A short-format write is 65 clocked bits.
- R5: Reads release the line for the turnaround bit. If the turnaround is 0, the block samples 16 bits MSB first into `rdata_o`, then clocks one more released bit, giving 64 bits for a short-format read.
- R6: A read whose turnaround is 1, for a PHY whose `ta_mask_i` bit is clear, clocks 32 more released bits and returns `rdata_o` = 16'hFFFF (79 bits for short format).
- R7: If the `ta_mask_i` bit for the addressed PHY is set, a turnaround of 1 is accepted and the read proceeds as in R5.
- R8: An extended access is two frames, each with start bits 0,0 and `addr_i[20:16]` in the 5-bit register field. The first is an address frame with opcode 0,0 and data `addr_i[15:0]`. The second has opcode 1,1 for read or 0,1 for write.
- R9: `mdc_o` stays high for `HALF_CYC` cycles on bits the master drives and for `READ_HI_CYC` cycles on released bits. It stays low for at least `HALF_CYC` cycles before each rising edge. `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low.
- R10: `busy_o` rises the cycle after an accepted start. `done_o` is a one-cycle pulse in the cycle `busy_o` falls. A start while busy is ignored, and the inputs are captured at acceptance.
- R11: Short-format opcodes come from `op_rd_i` (reads) and `op_wr_i` (writes), sent high bit first. With the values 2'b10 and 2'b01 they give the standard opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| c45_i | input | 1 | 1 = extended two-frame access |
| phy_i | input | 5 | PHY address |
| addr_i | input | 21 | Register address; [20:16] device, [15:0] extended register, [4:0] short register |
| wdata_i | input | 16 | Write data |
| op_rd_i | input | 2 | Short-format read opcode |
| op_wr_i | input | 2 | Short-format write opcode |
| ta_mask_i | input | 32 | Per-PHY turnaround-ignore flags |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A sequencer that lands in the wrong state or bit count shows up as a wrong clocked-bit count or a misplaced field in the bit stream recorded at `mdc_o` rising edges. This is visible by the end of the transaction at the latest. A fault in the turnaround decision shows up in both the total bit count (64 against 79) and in `rdata_o` at `done_o`. A phase-counter fault appears on the very first bit as a wrong high or low width of `mdc_o`, or as data moving while the clock is high.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} bit_phase_e;
  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_HDR, S_TAW, S_WDAT, S_TAR, S_RDAT, S_FLUSH, S_TAIL
  } seq_state_e;
  localparam logic [1:0] SOF_SHORT = 2'b01;
  localparam logic [1:0] SOF_EXT   = 2'b00;
  localparam logic [1:0] OPX_ADDR  = 2'b00;
  localparam logic [1:0] OPX_WR    = 2'b01;
  localparam logic [1:0] OPX_RD    = 2'b11;
endpackage

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine
  import mdio_pkg::*;
#(
  parameter int HALF_CYC    = 13,
  parameter int READ_HI_CYC = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic drive_i,
  input  logic val_i,
  input  logic long_i,
  input  logic mdio_i,
  output logic mdc_o,
  output logic mdio_o,
  output logic oe_o,
  output logic done_o,
  output logic sample_o
);
  localparam int MAXC  = (HALF_CYC > READ_HI_CYC) ? HALF_CYC : READ_HI_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LD = CNT_W'(READ_HI_CYC - 1);

  bit_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      long_q   <= 1'b0;
      mdc_o    <= 1'b0;
      mdio_o   <= 1'b0;
      oe_o     <= 1'b0;
      done_o   <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q   <= PH_LOW;
          cnt_q  <= HALF_LD;
          long_q <= long_i;
          oe_o   <= drive_i;
          if (drive_i) mdio_o <= val_i;
        end
        PH_LOW: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_HIGH;
            mdc_o <= 1'b1;
            cnt_q <= long_q ? READ_LD : HALF_LD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == '0) begin
            ph_q     <= PH_IDLE;
            mdc_o    <= 1'b0;
            done_o   <= 1'b1;
            sample_o <= mdio_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R9: line value frozen across the high phase
  p_hold_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(oe_o)));
  // R9: bit completes on the falling edge of the clock
  p_done_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mdc_o && $fell(mdc_o)));
endmodule

// File: rtl/mdio_sequencer.sv
module mdio_sequencer
  import mdio_pkg::*;
#(
  parameter int PHY_W      = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int PRE_BITS   = 32,
  parameter int FLUSH_BITS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  rd_i,
  input  logic                  c45_i,
  input  logic [PHY_W-1:0]      phy_i,
  input  logic [REG_W+DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [1:0]            op_rd_i,
  input  logic [1:0]            op_wr_i,
  input  logic [2**PHY_W-1:0]   ta_mask_i,
  input  logic                  eng_done_i,
  input  logic                  eng_sample_i,
  output logic                  go_o,
  output logic                  drive_o,
  output logic                  val_o,
  output logic                  long_o,
  output logic                  pre_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int ADDR_W = REG_W + DATA_W;
  localparam int HDR_W  = 4 + PHY_W + REG_W;
  localparam int SH_W   = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int M1     = (PRE_BITS > FLUSH_BITS) ? PRE_BITS : FLUSH_BITS;
  localparam int M2     = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int MAXB   = (M1 > M2) ? M1 : M2;
  localparam int CNT_W  = $clog2(MAXB);

  seq_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic              rd_q, c45_q, aframe_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] alo_q, wdata_q;
  logic [1:0]        op_rd_q, op_wr_q;

  logic [1:0]        sof_w, op_w;
  logic [HDR_W-1:0]  hdr_w;
  logic              wr_like_w;

  always_comb begin
    sof_w = c45_q ? SOF_EXT : SOF_SHORT;
    if (c45_q) op_w = aframe_q ? OPX_ADDR : (rd_q ? OPX_RD : OPX_WR);
    else       op_w = rd_q ? op_rd_q : op_wr_q;
    hdr_w     = {sof_w, op_w, phy_q, reg_q};
    wr_like_w = aframe_q || !rd_q;
  end

  always_comb begin
    drive_o = 1'b0;
    val_o   = 1'b0;
    unique case (st_q)
      S_PRE:         begin drive_o = 1'b1; val_o = 1'b1;           end
      S_HDR, S_WDAT: begin drive_o = 1'b1; val_o = sh_q[SH_W-1];   end
      S_TAW:         begin drive_o = 1'b1; val_o = cnt_q[0];       end
      default:       ;
    endcase
    long_o = !drive_o;
    pre_o  = (st_q == S_PRE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_q     <= 1'b0;
      c45_q    <= 1'b0;
      aframe_q <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      alo_q    <= '0;
      wdata_q  <= '0;
      op_rd_q  <= '0;
      op_wr_q  <= '0;
      go_o     <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      go_o   <= 1'b0;
      done_o <= 1'b0;
      if (st_q == S_IDLE) begin
        if (start_i) begin
          rd_q     <= rd_i;
          c45_q    <= c45_i;
          aframe_q <= c45_i;
          phy_q    <= phy_i;
          reg_q    <= c45_i ? addr_i[ADDR_W-1 -: REG_W] : addr_i[REG_W-1:0];
          alo_q    <= addr_i[DATA_W-1:0];
          wdata_q  <= wdata_i;
          op_rd_q  <= op_rd_i;
          op_wr_q  <= op_wr_i;
          st_q     <= S_PRE;
          cnt_q    <= CNT_W'(PRE_BITS - 1);
          busy_o   <= 1'b1;
          go_o     <= 1'b1;
        end
      end else if (eng_done_i) begin
        go_o <= 1'b1;
        case (st_q)
          S_PRE: begin
            if (cnt_q == '0) begin
              st_q  <= S_HDR;
              sh_q  <= SH_W'(hdr_w) << (SH_W - HDR_W);
              cnt_q <= CNT_W'(HDR_W - 1);
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_HDR: begin
            sh_q <= sh_q << 1;
            if (cnt_q == '0) begin
              if (wr_like_w) begin
                st_q  <= S_TAW;
                cnt_q <= CNT_W'(1);
              end else begin
                st_q <= S_TAR;
              end
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_TAW: begin
            if (cnt_q == '0) begin
              st_q  <= S_WDAT;
              sh_q  <= SH_W'(aframe_q ? alo_q : wdata_q) << (SH_W - DATA_W);
              cnt_q <= CNT_W'(DATA_W - 1);
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_WDAT: begin
            sh_q <= sh_q << 1;
            if (cnt_q == '0) st_q <= S_TAIL;
            else cnt_q <= cnt_q - 1'b1;
          end
          S_TAR: begin
            if (eng_sample_i && !ta_mask_i[phy_q]) begin
              st_q  <= S_FLUSH;
              cnt_q <= CNT_W'(FLUSH_BITS - 1);
            end else begin
              st_q  <= S_RDAT;
              cnt_q <= CNT_W'(DATA_W - 1);
            end
          end
          S_RDAT: begin
            rdata_o <= {rdata_o[DATA_W-2:0], eng_sample_i};
            if (cnt_q == '0) st_q <= S_TAIL;
            else cnt_q <= cnt_q - 1'b1;
          end
          S_FLUSH: begin
            if (cnt_q == '0) begin
              rdata_o <= '1;
              st_q    <= S_IDLE;
              go_o    <= 1'b0;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_TAIL: begin
            if (aframe_q) begin
              aframe_q <= 1'b0;
              st_q     <= S_PRE;
              cnt_q    <= CNT_W'(PRE_BITS - 1);
            end else begin
              st_q   <= S_IDLE;
              go_o   <= 1'b0;
              busy_o <= 1'b0;
              done_o <= 1'b1;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  // R10: captured request holds for the whole transaction
  p_capture_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(phy_q) && $stable(rd_q) && $stable(c45_q)));
  // R10: completion coincides with busy dropping
  p_done_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $fell(busy_o)));
  // R6: flushed read returns all ones
  p_flush_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(st_q == S_FLUSH)) |-> (rdata_o == '1));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CYC    = 13,
  parameter int READ_HI_CYC = 18,
  parameter int PHY_W       = 5,
  parameter int REG_W       = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_BITS    = 32,
  parameter int FLUSH_BITS  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    rd_i,
  input  logic                    c45_i,
  input  logic [PHY_W-1:0]        phy_i,
  input  logic [REG_W+DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [1:0]              op_rd_i,
  input  logic [1:0]              op_wr_i,
  input  logic [2**PHY_W-1:0]     ta_mask_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    mdc_o,
  output logic                    mdio_o,
  output logic                    mdio_oe_o,
  input  logic                    mdio_i
);
  logic go_w, drive_w, val_w, long_w, pre_w, eng_done_w, eng_sample_w;

  mdio_sequencer #(
    .PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W),
    .PRE_BITS(PRE_BITS), .FLUSH_BITS(FLUSH_BITS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i),
    .c45_i(c45_i), .phy_i(phy_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .op_rd_i(op_rd_i), .op_wr_i(op_wr_i), .ta_mask_i(ta_mask_i),
    .eng_done_i(eng_done_w), .eng_sample_i(eng_sample_w),
    .go_o(go_w), .drive_o(drive_w), .val_o(val_w), .long_o(long_w),
    .pre_o(pre_w), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  mdio_bit_engine #(.HALF_CYC(HALF_CYC), .READ_HI_CYC(READ_HI_CYC)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_w), .drive_i(drive_w),
    .val_i(val_w), .long_i(long_w), .mdio_i(mdio_i), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .oe_o(mdio_oe_o), .done_o(eng_done_w),
    .sample_o(eng_sample_w)
  );

  // R2: preamble bits are driven ones
  p_pre_ones_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_w && mdc_o) |-> (mdio_oe_o && mdio_o));
  // R5: sampled bits never see the master driving
  p_release_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !drive_w && mdc_o) |-> !mdio_oe_o);
  // R9: clock idles low outside a transaction
  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !mdc_o);
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PER = 10;
  localparam int HALF    = 2;
  localparam int RHI     = 3;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, rd = 0, c45 = 0;
  logic [4:0]  phy = 0;
  logic [20:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [1:0]  op_rd = 2'b10, op_wr = 2'b01;
  logic [31:0] mask = 0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1;
  logic [15:0] rdata;

  always #(CLK_PER/2) clk = ~clk;

  mdio_master #(.HALF_CYC(HALF), .READ_HI_CYC(RHI)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd), .c45_i(c45),
    .phy_i(phy), .addr_i(addr), .wdata_i(wdata), .op_rd_i(op_rd),
    .op_wr_i(op_wr), .ta_mask_i(mask), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_i)
  );

  int n_chk = 0, n_fail = 0;
  logic rec_oe [0:255], rec_val [0:255], exp_oe [0:255], exp_val [0:255];
  int nb = 0, en = 0, dn = 0, tbad = 0, lc = 100, hc = 0;
  logic prev_mdc = 0, prev_mdio = 0, prev_oe = 0, prev_done = 0;
  int m_ofs = 0;
  logic m_rd = 0, m_ta = 0;
  logic [15:0] m_data = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor and PHY responder
  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      int rel;
      rec_oe[nb[7:0]] = mdio_oe;
      rec_val[nb[7:0]] = mdio_o;
      if (lc < HALF) tbad++;
      rel = nb - m_ofs;
      if (m_rd && rel == 46) mdio_i = m_ta;
      else if (m_rd && rel >= 47 && rel <= 62) mdio_i = m_data[62-rel];
      else mdio_i = 1'b1;
      nb++;
      hc = 1;
    end else if (mdc && prev_mdc) begin
      hc++;
      if (mdio_o !== prev_mdio || mdio_oe !== prev_oe) tbad++;
    end else if (!mdc && prev_mdc) begin
      if (hc != (rec_oe[(nb-1) & 255] ? HALF : RHI)) tbad++;
      lc = 1;
    end else begin
      lc++;
    end
    if (done) dn++;
    if (done && prev_done) tbad++;
    prev_mdc = mdc; prev_mdio = mdio_o; prev_oe = mdio_oe; prev_done = done;
  end

  task automatic push(input logic o, input logic v);
    exp_oe[en] = o; exp_val[en] = v; en++;
  endtask

  task automatic push_num(input logic [15:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) push(1'b1, v[i]);
  endtask

  task automatic add_frame(input logic [1:0] sof, input logic [1:0] op,
                           input logic [4:0] ph, input logic [4:0] rg,
                           input logic is_rd, input logic [15:0] d, input logic fl);
    for (int i = 0; i < 32; i++) push(1'b1, 1'b1);
    push(1'b1, sof[1]); push(1'b1, sof[0]); push(1'b1, op[1]); push(1'b1, op[0]);
    push_num({11'd0, ph}, 5);
    push_num({11'd0, rg}, 5);
    if (!is_rd) begin
      push(1'b1, 1'b1); push(1'b1, 1'b0); push_num(d, 16); push(1'b0, 1'b0);
    end else begin
      push(1'b0, 1'b0);
      for (int i = 0; i < (fl ? 32 : 17); i++) push(1'b0, 1'b0);
    end
  endtask

  task automatic xact(input logic r, input logic x, input logic [4:0] ph,
                      input logic [20:0] ad, input logic [15:0] d,
                      input logic ta_bad, input logic [31:0] mk,
                      input logic poke, input string tag);
    logic fl;
    int bad_i;
    string rq;
    fl = r && ta_bad && !mk[ph];
    en = 0;
    if (x) begin
      add_frame(2'b00, 2'b00, ph, ad[20:16], 1'b0, ad[15:0], 1'b0);
      add_frame(2'b00, r ? 2'b11 : 2'b01, ph, ad[20:16], r, d, fl);
    end else begin
      add_frame(2'b01, r ? op_rd : op_wr, ph, ad[4:0], r, d, fl);
    end
    @(negedge clk);
    m_ofs = x ? 65 : 0; m_rd = r; m_ta = ta_bad; m_data = d;
    nb = 0; dn = 0; tbad = 0;
    rd = r; c45 = x; phy = ph; addr = ad; wdata = d; mask = mk; start = 1;
    @(negedge clk);
    start = 0;
    rd = ~r; c45 = ~x; phy = ~ph; addr = ~ad; wdata = ~d;
    @(negedge clk);
    check(busy === 1'b1, "R10", {tag, " busy after start"}, {31'd0, busy}, 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (dn == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    mask = mk;
    bad_i = -1;
    for (int i = 0; i < en; i++)
      if (bad_i < 0 && (rec_oe[i] !== exp_oe[i] || (exp_oe[i] && rec_val[i] !== exp_val[i])))
        bad_i = i;
    begin
      int rel;
      rel = (x && bad_i >= 65) ? bad_i - 65 : bad_i;
      rq = (rel < 32) ? "R2" : (rel < 46) ? (x ? "R8" : "R3") : tag;
    end
    check(nb == en, tag, "clocked bit count", nb, en);
    check(bad_i < 0, rq, $sformatf("%s stream bit %0d {oe,val}", tag, bad_i),
          (bad_i < 0) ? 0 : {rec_oe[bad_i], rec_val[bad_i]},
          (bad_i < 0) ? 0 : {exp_oe[bad_i], exp_val[bad_i]});
    if (r) check(rdata === (fl ? 16'hFFFF : d), fl ? "R6" : tag, "read data", rdata,
                 fl ? 16'hFFFF : d);
    check(tbad == 0, "R9", {tag, " clock phase / hold violations"}, tbad, 0);
    check(dn == 1 && busy === 1'b0, "R10", {tag, " single done, idle after"}, dn, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(mdc === 0 && mdio_oe === 0 && busy === 0 && done === 0, "R1",
          "reset outputs", {mdc, mdio_oe, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(mdc === 0 && mdio_oe === 0 && busy === 0, "R1", "idle after reset",
          {mdc, mdio_oe, busy}, 0);
    // R4 / R5 short-format sweeps over every PHY address
    for (int p = 0; p < 32; p++) begin
      xact(1'b0, 1'b0, 5'(p), {16'd0, 5'(p) ^ 5'h15}, 16'(p * 16'h0842 ^ 16'hA5C3),
           1'b0, 32'd0, 1'b0, "R4");
      xact(1'b1, 1'b0, 5'(p), {16'd0, 5'(31 - p)}, 16'(p * 16'h1111 ^ 16'h5A3C),
           1'b0, 32'd0, 1'b0, "R5");
    end
    // R6 bad turnaround, only a different PHY masked; R7 masked PHY
    for (int p = 0; p < 8; p++) begin
      xact(1'b1, 1'b0, 5'(p), 21'h3, 16'h1234, 1'b1, 32'd1 << (p + 1), 1'b0, "R6");
      xact(1'b1, 1'b0, 5'(p), 21'h3, 16'hC0DE ^ 16'(p), 1'b1, 32'd1 << p, 1'b0, "R7");
    end
    // R8 extended access
    xact(1'b0, 1'b1, 5'h09, 21'h1A_BCD, 16'hBEEF, 1'b0, 32'd0, 1'b0, "R8");
    xact(1'b1, 1'b1, 5'h12, 21'h05_0F0F, 16'h8001, 1'b0, 32'd0, 1'b0, "R8");
    xact(1'b1, 1'b1, 5'h1F, 21'h1F_FFFF, 16'h7E7E, 1'b1, 32'd0, 1'b0, "R8");
    // R11 opcode override
    op_rd = 2'b00; op_wr = 2'b11;
    xact(1'b0, 1'b0, 5'h04, 21'h11, 16'h0F0F, 1'b0, 32'd0, 1'b0, "R11");
    xact(1'b1, 1'b0, 5'h04, 21'h11, 16'hF00F, 1'b0, 32'd0, 1'b0, "R11");
    op_rd = 2'b10; op_wr = 2'b01;
    // R10 start while busy ignored
    xact(1'b1, 1'b0, 5'h0A, 21'h07, 16'h3C3C, 1'b0, 32'd0, 1'b1, "R10");
    xact(1'b0, 1'b1, 5'h0B, 21'h02_1234, 16'h4321, 1'b0, 32'd0, 1'b1, "R10");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule